// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs single-byte external memory and I/O transfers for an 8-bit controller core. The transfers go over a bus where one 8-bit port carries first the low address byte and then the data byte. The core raises a request with a 16-bit address, write data, a direction flag, a flag that picks data memory or program memory, and a flag that asks for stretched timing. The controller then sequences the address strobe, the data strobe, the read/write line and the data-memory select. It drives or releases the shared port, captures read data, and gives a one-clock done pulse at the end.

The sequencer moves through named states. `ST_IDLE` leaves the strobes inactive and the port released. A request seen in `ST_IDLE` is accepted (transition *accept*) and moves to `ST_SETUP`, where the address and cycle attributes are presented. Next is `ST_ASLOW`, where the address strobe is low, and then `ST_AHOLD`, where the strobe has risen and the address is still held. The cycle then enters `ST_DSLOW`, where the data strobe is low; it leaves this state on *strobe expiry*, when the phase timer reaches zero. `ST_DHOLD` follows, with the data strobe high, write data and direction still held, and done asserted. The cycle then returns to `ST_IDLE` (transition *retire*). A normal cycle takes 6 clocks from acceptance and an extended cycle takes 8.

Top module: `ebc_mux_bus`

## Requirements
- R1: While reset is asserted, and in idle, as_n_o=1, ds_n_o=1, rw_o=1, dm_n_o=1, ad_oe_o=0 and done_o=0.
- R2: In the first clock after acceptance, the port drives the address low byte with ad_oe_o=1 and as_n_o=1. In the second clock as_n_o=0 with the same address driven. as_n_o is low for exactly one clock per cycle.
- R3: In the clock after as_n_o rises, the address is still driven and ds_n_o is still high. The address strobe and the data strobe are never low together.
- R4: From the first cycle clock through the done clock, rw_o is 1 for a read and 0 for a write, and dm_n_o is 0 for a data-memory access and 1 for a program-memory access.
- R5: For a write, ad_oe_o=1 and ad_o holds the write byte in every clock that ds_n_o is low and in the clock after it rises.
- R6: For a read, ad_oe_o=0 while ds_n_o is low. rdata_o holds the value that was on ad_i at the clock edge where ds_n_o rises, and later changes on ad_i do not alter it.
- R7: ds_n_o stays low for 2 clocks in normal timing and 4 clocks in extended timing (ext_i=1).
- R8: done_o is high for exactly one clock, the clock right after ds_n_o rises, which is the 6th clock after acceptance (8th when extended). The controller is idle in the next clock.
- R9: A request raised while a cycle is in progress has no effect. The current address stays on the port, and no new address strobe follows unless a request is present in idle.
- R10: ahi_o shows the upper address byte from the first clock of a cycle and keeps it after the cycle until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, sampled in idle |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 8 | Write byte |
| wr_i | input | 1 | 1 = write, 0 = read |
| dmem_i | input | 1 | 1 = data memory, 0 = program memory |
| ext_i | input | 1 | 1 = stretched data strobe |
| ad_i | input | 8 | Shared port, value seen at pins |
| ad_o | output | 8 | Shared port, driven value |
| ad_oe_o | output | 1 | Shared port drive enable |
| ahi_o | output | 8 | Upper address byte |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| dm_n_o | output | 1 | Data-memory select, active low |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
Every output comes from a decode of the present state, so a wrong state appears at the strobes or at the port drive enable in the same clock. Examples are a second address-strobe clock, a data strobe overlapping the address strobe, or write data missing from the port. A phase timer loaded with the wrong value shows up first as a data strobe of the wrong width. It then shows as done arriving at the wrong clock count. A read capture on the wrong edge shows as a wrong rdata_o at the done clock. The bench therefore counts clocks from acceptance and checks each strobe's level at every clock, not only at the end.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ASLOW,
        ST_AHOLD,
        ST_DSLOW,
        ST_DHOLD
    } ebc_state_t;

    typedef struct packed {
        logic wr;
        logic dmem;
        logic ext;
    } ebc_attr_t;
endpackage

// File: rtl/ebc_ds_timer.sv
module ebc_ds_timer #(
    parameter int DS_NORM = 2,
    parameter int DS_XTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    input  logic ext_i,
    output logic zero_o
);
    localparam int DS_LONG = DS_NORM + DS_XTRA;
    localparam int CW      = $clog2(DS_LONG + 1);
    localparam logic [CW-1:0] LD_NORM = CW'(DS_NORM - 1);
    localparam logic [CW-1:0] LD_LONG = CW'(DS_LONG - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= ext_i ? LD_LONG : LD_NORM;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebc_req_regs.sv
module ebc_req_regs
    import ebc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  ebc_attr_t     attr_i,
    input  logic          cap_i,
    input  logic [DW-1:0] ad_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output ebc_attr_t     attr_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            attr_q  <= '0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            attr_q  <= attr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cap_i) begin
            rdata_q <= ad_i;
        end
    end
endmodule

// File: rtl/ebc_sequencer.sv
module ebc_sequencer
    import ebc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       tmr_zero_i,
    output ebc_state_t state_o,
    output logic       accept_o,
    output logic       tmr_load_o,
    output logic       tmr_run_o,
    output logic       as_n_o,
    output logic       ds_n_o,
    output logic       addr_ph_o,
    output logic       data_ph_o,
    output logic       active_o,
    output logic       done_o
);
    ebc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_ASLOW;
            ST_ASLOW: state_d = ST_AHOLD;
            ST_AHOLD: state_d = ST_DSLOW;
            ST_DSLOW: if (tmr_zero_i) state_d = ST_DHOLD;
            ST_DHOLD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        as_n_o     = 1'b1;
        ds_n_o     = 1'b1;
        addr_ph_o  = 1'b0;
        data_ph_o  = 1'b0;
        active_o   = 1'b1;
        done_o     = 1'b0;
        accept_o   = 1'b0;
        tmr_load_o = 1'b0;
        tmr_run_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                active_o = 1'b0;
                accept_o = req_i;
            end
            ST_SETUP: addr_ph_o = 1'b1;
            ST_ASLOW: begin
                addr_ph_o = 1'b1;
                as_n_o    = 1'b0;
            end
            ST_AHOLD: begin
                addr_ph_o  = 1'b1;
                tmr_load_o = 1'b1;
            end
            ST_DSLOW: begin
                data_ph_o = 1'b1;
                ds_n_o    = 1'b0;
                tmr_run_o = 1'b1;
            end
            ST_DHOLD: begin
                data_ph_o = 1'b1;
                done_o    = 1'b1;
            end
            default: active_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ebc_mux_bus.sv
module ebc_mux_bus
    import ebc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int DS_NORM = 2,
    parameter int DS_XTRA = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          dmem_i,
    input  logic          ext_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [AW-DW-1:0] ahi_o,
    output logic          as_n_o,
    output logic          ds_n_o,
    output logic          rw_o,
    output logic          dm_n_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    ebc_state_t    state;
    ebc_attr_t     attr_in, attr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic accept, tmr_load, tmr_run, tmr_zero;
    logic addr_ph, data_ph, active, cap;

    assign attr_in = '{wr: wr_i, dmem: dmem_i, ext: ext_i};

    ebc_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .tmr_zero_i (tmr_zero),
        .state_o    (state),
        .accept_o   (accept),
        .tmr_load_o (tmr_load),
        .tmr_run_o  (tmr_run),
        .as_n_o     (as_n_o),
        .ds_n_o     (ds_n_o),
        .addr_ph_o  (addr_ph),
        .data_ph_o  (data_ph),
        .active_o   (active),
        .done_o     (done_o)
    );

    ebc_ds_timer #(.DS_NORM(DS_NORM), .DS_XTRA(DS_XTRA)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .run_i  (tmr_run),
        .ext_i  (attr_q.ext),
        .zero_o (tmr_zero)
    );

    assign cap = (state == ST_DSLOW) && tmr_zero && !attr_q.wr;

    ebc_req_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .attr_i   (attr_in),
        .cap_i    (cap),
        .ad_i     (ad_i),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .attr_q   (attr_q),
        .rdata_q  (rdata_o)
    );

    assign ad_o    = addr_ph ? addr_q[DW-1:0] : wdata_q;
    assign ad_oe_o = addr_ph || (data_ph && attr_q.wr);
    assign ahi_o   = addr_q[AW-1:DW];
    assign rw_o    = active ? !attr_q.wr   : 1'b1;
    assign dm_n_o  = active ? !attr_q.dmem : 1'b1;
endmodule

// File: rtl/ebc_mux_bus_chk.sv
module ebc_mux_bus_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ad_o,
    input logic          ad_oe_o,
    input logic          as_n_o,
    input logic          ds_n_o,
    input logic          rw_o,
    input logic          done_o
);
    // R2: address strobe low for a single clock
    a_r2_as_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n_o |=> as_n_o);

    // R3: strobes never overlap
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_o || ds_n_o);

    // R3: address kept on the port through the clock after the strobe rises
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n_o) |-> ad_oe_o && $stable(ad_o) && ds_n_o);

    // R4: direction unchanged across the address-strobe rise and the data-strobe rise
    a_r4_rw_stable_as: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n_o) |-> $stable(rw_o));
    a_r4_rw_stable_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n_o) |-> $stable(rw_o));

    // R5: write data driven while the data strobe is low
    a_r5_wr_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && !rw_o) |-> ad_oe_o);

    // R6: port released for reads while the data strobe is low
    a_r6_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && rw_o) |-> !ad_oe_o);

    // R8: done coincides with the data-strobe rise and lasts one clock
    a_r8_done_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n_o) |-> done_o);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind ebc_mux_bus ebc_mux_bus_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .as_n_o  (as_n_o),
    .ds_n_o  (ds_n_o),
    .rw_o    (rw_o),
    .done_o  (done_o)
);

// File: tb/sim_ebc_mux_bus.sv
`timescale 1ns/1ps
module sim_ebc_mux_bus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        wr_i = 1'b0, dmem_i = 1'b0, ext_i = 1'b0;
    logic [7:0]  ad_i = '0;
    logic [7:0]  ad_o, ahi_o, rdata_o;
    logic        ad_oe_o, as_n_o, ds_n_o, rw_o, dm_n_o, done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ebc_mux_bus u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wr_i(wr_i), .dmem_i(dmem_i), .ext_i(ext_i),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ahi_o(ahi_o),
        .as_n_o(as_n_o), .ds_n_o(ds_n_o), .rw_o(rw_o), .dm_n_o(dm_n_o),
        .rdata_o(rdata_o), .done_o(done_o)
    );

    // {wr, dmem, ext, addr[15:0], data[7:0]}
    localparam logic [26:0] VEC [6] = '{
        {1'b1, 1'b1, 1'b0, 16'h12A5, 8'h3C},
        {1'b0, 1'b1, 1'b0, 16'h80F0, 8'h96},
        {1'b1, 1'b0, 1'b1, 16'hFE01, 8'h00},
        {1'b0, 1'b0, 1'b1, 16'h0055, 8'hFF},
        {1'b1, 1'b1, 1'b1, 16'h7F7F, 8'hA5},
        {1'b0, 1'b0, 1'b0, 16'hC3AA, 8'h5A}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        chk({tag, " R1 as_n"}, 16'(as_n_o), 16'd1);
        chk({tag, " R1 ds_n"}, 16'(ds_n_o), 16'd1);
        chk({tag, " R1 rw"}, 16'(rw_o), 16'd1);
        chk({tag, " R1 dm_n"}, 16'(dm_n_o), 16'd1);
        chk({tag, " R1 oe"}, 16'(ad_oe_o), 16'd0);
        chk({tag, " R1 done"}, 16'(done_o), 16'd0);
    endtask

    // Drives one request, then checks every clock until done. stray_at>0 raises
    // a second request during that observation clock.
    task automatic run_cycle(input logic wr, input logic dm, input logic ext,
                             input logic [15:0] addr, input logic [7:0] data,
                             input int stray_at);
        int ds_low = 0;
        int as_low = 0;
        int done_idx = 0;
        int ds_len = ext ? 4 : 2;
        int len = 4 + ds_len;
        @(negedge clk);
        req_i = 1'b1; addr_i = addr; wdata_i = data;
        wr_i = wr; dmem_i = dm; ext_i = ext;
        ad_i = ~data;
        @(negedge clk);
        req_i = 1'b0; addr_i = ~addr; wdata_i = ~data; wr_i = ~wr; ext_i = ~ext;
        for (int i = 1; i <= len; i++) begin
            if (i == stray_at) begin
                req_i = 1'b1; addr_i = 16'h9999;
            end else begin
                req_i = 1'b0;
            end
            chk("R4 rw", 16'(rw_o), 16'(!wr));
            chk("R4 dm_n", 16'(dm_n_o), 16'(!dm));
            chk("R10 ahi", 16'(ahi_o), 16'(addr[15:8]));
            chk("R3 no overlap", 16'(as_n_o | ds_n_o), 16'd1);
            if (i <= 3) begin
                chk("R2 addr on port", {8'h0, ad_o}, {8'h0, addr[7:0]});
                chk("R2 oe", 16'(ad_oe_o), 16'd1);
                chk("R2 as_n", 16'(as_n_o), 16'(i != 2));
                chk("R3 ds_n high", 16'(ds_n_o), 16'd1);
            end
            if (!as_n_o) as_low++;
            if (!ds_n_o) begin
                ds_low++;
                if (wr) begin
                    chk("R5 wdata", {8'h0, ad_o}, {8'h0, data});
                    chk("R5 oe", 16'(ad_oe_o), 16'd1);
                end else begin
                    chk("R6 released", 16'(ad_oe_o), 16'd0);
                    ad_i = data;
                end
            end
            if (done_o) begin
                if (done_idx == 0) done_idx = i;
                if (wr) begin
                    chk("R5 wdata hold", {8'h0, ad_o}, {8'h0, data});
                    chk("R5 oe hold", 16'(ad_oe_o), 16'd1);
                end else begin
                    ad_i = ~data;
                end
            end
            @(negedge clk);
        end
        req_i = 1'b0;
        chk("R2 one as clock", 16'(as_low), 16'd1);
        chk("R7 ds width", 16'(ds_low), 16'(ds_len));
        chk("R8 done clock", 16'(done_idx), 16'(len));
        chk("R8 done single", 16'(done_o), 16'd0);
        chk("R8 idle after", 16'(as_n_o & ds_n_o & !ad_oe_o), 16'd1);
        if (!wr) chk("R6 rdata", {8'h0, rdata_o}, {8'h0, data});
        chk("R10 ahi kept", 16'(ahi_o), 16'(addr[15:8]));
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1;
        idle_check("reset");
        repeat (3) @(negedge clk);
        idle_check("reset held");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("idle");

        for (int v = 0; v < 6; v++) begin
            run_cycle(VEC[v][26], VEC[v][25], VEC[v][24], VEC[v][23:8], VEC[v][7:0], 0);
        end

        // R6: port changes after capture leave rdata unchanged
        ad_i = 8'h11;
        repeat (2) @(negedge clk);
        chk("R6 rdata kept", {8'h0, rdata_o}, 16'h005A);

        // R9: request during a busy cycle is ignored
        run_cycle(1'b1, 1'b0, 1'b0, 16'h4321, 8'hC7, 2);
        for (int k = 0; k < 4; k++) begin
            chk("R9 no new strobe", 16'(as_n_o), 16'd1);
            chk("R9 port idle", 16'(ad_oe_o), 16'd0);
            chk("R10 ahi after stray", 16'(ahi_o), 16'h0043);
            @(negedge clk);
        end

        // R9: stray request in the first clock also ignored (extended read)
        run_cycle(1'b0, 1'b1, 1'b1, 16'hABCD, 8'h81, 1);
        chk("R9 idle after", 16'(as_n_o), 16'd1);

        // R1: reset in mid cycle forces idle outputs
        @(negedge clk);
        req_i = 1'b1; addr_i = 16'h2222; wr_i = 1'b1; dmem_i = 1'b1; ext_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 ds low before reset", 16'(ds_n_o), 16'd0);
        rst_n = 1'b0;
        #1;
        idle_check("mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_check("after reset");

        run_cycle(1'b0, 1'b1, 1'b0, 16'h0102, 8'hE4, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule